// File: doc/BRIEF.md
# Programmable Pixel Row Sequencer

This block drives the row control lines of a column-parallel pixel array. The waveform on those lines is not fixed in logic. A pattern of 16 steps is shifted in one bit at a time while the block is in programming mode. In run mode the block replays that pattern once per row, one step per clock. The six per-row lines are power enable, diode reset, clamp reset, first read, second read and discriminator latch. The read strobes and the latch feed the column readout. Within a slot, the pattern normally orders them as: read, diode reset, clamp reset, second read, then latch.

After the last step of a slot, a row counter advances to the next row and wraps back to row 0 after the last row. With the default of 128 rows at a 100 MHz clock, each slot takes 160 ns and a frame takes about 20 µs. A one-cycle frame sync marks step 0 of row 0, so external equipment can trigger on the frame start. A run input pauses the sequence, and a synchronous reset restarts it. Neither touches the stored pattern.

Top module: `pix_row_sequencer`

## Requirements
- R1: While `progEn` is high and `rst` is low, every clock with `progStrobe` high shifts `progBit` into a 96-bit pattern store. The bit order is MSB-first: the first of 96 bits lands at step 15, line 5, and the last lands at step 0, line 0. Line indices are: 0 `pwrOn`, 1 `diodeRst`, 2 `clampRst`, 3 `rdStrobe`, 4 `calStrobe`, 5 `latchStb`.
- R2: While playing (`runEn` high, `progEn` low, `rst` low), each rising edge puts the stored word of the current step on the six control outputs and advances the step index by one, modulo 16.
- R3: After step 15 is played, the row index advances by one. `rowSel` always shows the row of the step currently on the outputs.
- R4: The row after the last row (127 by default) is row 0.
- R5: `frameSync` is high for exactly the one cycle in which step 0 of row 0 is on the outputs, and low at all other times.
- R6: While `runEn` is low, the step and row indices hold, all six control outputs and `frameSync` are low, and `rowSel` shows the held row. Playback resumes from the held step.
- R7: While `progEn` is high, playback is blocked in the same way as R6, whatever the value of `runEn`.
- R8: A clock edge with `rst` high clears the step and row indices, `rowSel` and all outputs. The stored pattern is kept.
- R9: On the first edge after reset is released with `runEn` high, the outputs show step 0 of row 0 and `frameSync` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| progEn | input | 1 | Programming mode; blocks playback |
| progStrobe | input | 1 | One-cycle shift request for the serial pattern bit |
| progBit | input | 1 | Serial pattern data, MSB-first |
| runEn | input | 1 | Run (high) or hold (low) |
| pwrOn | output | 1 | Row power enable |
| diodeRst | output | 1 | Sensing diode reset |
| clampRst | output | 1 | Clamp capacitor reset |
| rdStrobe | output | 1 | First read strobe to the columns |
| calStrobe | output | 1 | Second (reference) read strobe to the columns |
| latchStb | output | 1 | Column discriminator latch |
| rowSel | output | 7 | Index of the selected row |
| frameSync | output | 1 | One-cycle frame start marker |

## Verification
Several events fall on the same clock edge:
- On the last step of the last row, the step wrap and the row wrap happen together, and the frame sync follows on the very next cycle.
- A hold can arrive on exactly that boundary cycle.

The bench runs two full frames. It checks every cycle against a position it tracks itself: step = position mod 16 and row = position / 16. It then drops `runEn` while step 15 of row 127 is still pending. The outputs must stay low with `rowSel` at 127. On resume, step 15 of row 127 must appear first, with no sync, and step 0 of row 0 must follow with the sync.

// File: rtl/pix_seq_pkg.sv
package pix_seq_pkg;

  localparam int LINE_COUNT = 6;

  // Packed so that bit 0 is pwrOn and bit 5 is latchStb
  typedef struct packed {
    logic latchStb;
    logic calStrobe;
    logic rdStrobe;
    logic clampRst;
    logic diodeRst;
    logic pwrOn;
  } lineWord_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic play;
    logic shift;
    logic frameStart;
  } seqCmd_t;

endpackage

// File: rtl/pix_seq_ctrl.sv
module pix_seq_ctrl
  import pix_seq_pkg::*;
#(
  parameter int STEPS    = 16,
  parameter int NUM_ROWS = 128,
  localparam int STEP_W  = $clog2(STEPS),
  localparam int ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              progEn,
  input  logic              progStrobe,
  input  logic              runEn,
  output seqCmd_t           cmd,
  output logic [STEP_W-1:0] stepIdx,
  output logic [ROW_W-1:0]  rowIdx
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);
  localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(NUM_ROWS - 1);

  logic [STEP_W-1:0] stepCnt;
  logic [ROW_W-1:0]  rowCnt;
  logic              stepWrap;

  assign stepWrap       = (stepCnt == LAST_STEP);
  assign cmd.play       = !rst && runEn && !progEn;
  assign cmd.shift      = !rst && progEn && progStrobe;
  assign cmd.frameStart = cmd.play && (stepCnt == '0) && (rowCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      stepCnt <= '0;
      rowCnt  <= '0;
    end else if (cmd.play) begin
      if (stepWrap) begin
        stepCnt <= '0;
        rowCnt  <= (rowCnt == LAST_ROW) ? '0 : rowCnt + 1'b1;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign stepIdx = stepCnt;
  assign rowIdx  = rowCnt;

  // R2: one step per played cycle, modulo the slot length
  assert_step_advance_R2: assert property (@(posedge clk) disable iff (rst)
    cmd.play |=> stepCnt == (($past(stepCnt) == LAST_STEP) ? '0 : $past(stepCnt) + 1'b1));

  // R3 and R4: row moves only at the end of a slot, wrapping after the last row
  assert_row_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd.play && stepWrap) |=> rowCnt == (($past(rowCnt) == LAST_ROW) ? '0 : $past(rowCnt) + 1'b1));

  assert_row_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd.play && !stepWrap) |=> $stable(rowCnt));

  // R6: counters hold when not playing
  assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    !runEn |=> ($stable(stepCnt) && $stable(rowCnt)));

  // R7: programming mode blocks the step counter
  assert_prog_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    progEn |=> $stable(stepCnt));

endmodule

// File: rtl/pix_seq_dpath.sv
module pix_seq_dpath
  import pix_seq_pkg::*;
#(
  parameter int STEPS    = 16,
  parameter int NUM_ROWS = 128,
  localparam int STEP_W  = $clog2(STEPS),
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int STORE_W = STEPS * LINE_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCmd_t           cmd,
  input  logic [STEP_W-1:0] stepIdx,
  input  logic [ROW_W-1:0]  rowIdx,
  input  logic              progBit,
  output lineWord_t         lineOut,
  output logic [ROW_W-1:0]  rowOut,
  output logic              syncOut
);

  logic [STORE_W-1:0] patStore;
  lineWord_t          stepWord [STEPS];
  lineWord_t          selWord;
  lineWord_t          lineReg;
  logic [ROW_W-1:0]   rowReg;
  logic               syncReg;

  // Pattern store: no reset, so it survives a sequencer restart
  always_ff @(posedge clk) begin
    if (cmd.shift) patStore <= {patStore[STORE_W-2:0], progBit};
  end

  for (genvar g = 0; g < STEPS; g++) begin : g_unpack
    assign stepWord[g] = patStore[g*LINE_COUNT +: LINE_COUNT];
  end

  assign selWord = stepWord[stepIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      lineReg <= '0;
      rowReg  <= '0;
      syncReg <= 1'b0;
    end else begin
      lineReg <= cmd.play ? selWord : '0;
      rowReg  <= rowIdx;
      syncReg <= cmd.frameStart;
    end
  end

  assign lineOut = lineReg;
  assign rowOut  = rowReg;
  assign syncOut = syncReg;

  // R6 and R7: outputs quiet on the cycle after a non-playing edge
  assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !cmd.play |=> (lineReg == '0) && !syncReg);

  // R8: registers are clear right after reset is released
  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lineReg == '0) && (rowReg == '0) && !syncReg);

  // R5: the frame marker only appears on row 0 and never twice in a row
  assert_sync_row0_R5: assert property (@(posedge clk) disable iff (rst)
    syncReg |-> (rowReg == '0));

  assert_sync_single_R5: assert property (@(posedge clk) disable iff (rst)
    syncReg |=> !syncReg);

endmodule

// File: rtl/pix_row_sequencer.sv
module pix_row_sequencer
  import pix_seq_pkg::*;
#(
  parameter int STEPS    = 16,
  parameter int NUM_ROWS = 128,
  localparam int STEP_W  = $clog2(STEPS),
  localparam int ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             progEn,
  input  logic             progStrobe,
  input  logic             progBit,
  input  logic             runEn,
  output logic             pwrOn,
  output logic             diodeRst,
  output logic             clampRst,
  output logic             rdStrobe,
  output logic             calStrobe,
  output logic             latchStb,
  output logic [ROW_W-1:0] rowSel,
  output logic             frameSync
);

  seqCmd_t           cmd;
  logic [STEP_W-1:0] stepIdx;
  logic [ROW_W-1:0]  rowIdx;
  lineWord_t         lineOut;

  pix_seq_ctrl #(.STEPS(STEPS), .NUM_ROWS(NUM_ROWS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .progEn     (progEn),
    .progStrobe (progStrobe),
    .runEn      (runEn),
    .cmd        (cmd),
    .stepIdx    (stepIdx),
    .rowIdx     (rowIdx)
  );

  pix_seq_dpath #(.STEPS(STEPS), .NUM_ROWS(NUM_ROWS)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .stepIdx (stepIdx),
    .rowIdx  (rowIdx),
    .progBit (progBit),
    .lineOut (lineOut),
    .rowOut  (rowSel),
    .syncOut (frameSync)
  );

  assign pwrOn     = lineOut.pwrOn;
  assign diodeRst  = lineOut.diodeRst;
  assign clampRst  = lineOut.clampRst;
  assign rdStrobe  = lineOut.rdStrobe;
  assign calStrobe = lineOut.calStrobe;
  assign latchStb  = lineOut.latchStb;

endmodule

// File: tb/pix_row_sequencer_bench.sv
module pix_row_sequencer_bench;

  localparam int ROWS   = 128;
  localparam int STEPS  = 16;
  localparam int FRAME  = ROWS * STEPS;
  localparam int NVEC   = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic progEn = 1'b0, progStrobe = 1'b0, progBit = 1'b0, runEn = 1'b0;
  logic pwrOn, diodeRst, clampRst, rdStrobe, calStrobe, latchStb, frameSync;
  logic [6:0] rowSel;

  int vectors = 0;
  int misses  = 0;
  int pos     = 0;
  logic [5:0] benchPat [STEPS];

  always #5 clk = ~clk;

  pix_row_sequencer u_pix_row_sequencer (
    .clk(clk), .rst(rst), .progEn(progEn), .progStrobe(progStrobe),
    .progBit(progBit), .runEn(runEn), .pwrOn(pwrOn), .diodeRst(diodeRst),
    .clampRst(clampRst), .rdStrobe(rdStrobe), .calStrobe(calStrobe),
    .latchStb(latchStb), .rowSel(rowSel), .frameSync(frameSync)
  );

  // {run, valid, step[3:0], row[6:0], sync}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 4'd0,  7'd0, 1'b1},
    {1'b1, 1'b1, 4'd1,  7'd0, 1'b0},
    {1'b1, 1'b1, 4'd2,  7'd0, 1'b0},
    {1'b1, 1'b1, 4'd3,  7'd0, 1'b0},
    {1'b1, 1'b1, 4'd4,  7'd0, 1'b0},
    {1'b1, 1'b1, 4'd5,  7'd0, 1'b0},
    {1'b1, 1'b1, 4'd6,  7'd0, 1'b0},
    {1'b1, 1'b1, 4'd7,  7'd0, 1'b0},
    {1'b1, 1'b1, 4'd8,  7'd0, 1'b0},
    {1'b1, 1'b1, 4'd9,  7'd0, 1'b0},
    {1'b1, 1'b1, 4'd10, 7'd0, 1'b0},
    {1'b1, 1'b1, 4'd11, 7'd0, 1'b0},
    {1'b1, 1'b1, 4'd12, 7'd0, 1'b0},
    {1'b1, 1'b1, 4'd13, 7'd0, 1'b0},
    {1'b1, 1'b1, 4'd14, 7'd0, 1'b0},
    {1'b1, 1'b1, 4'd15, 7'd0, 1'b0},
    {1'b1, 1'b1, 4'd0,  7'd1, 1'b0},
    {1'b0, 1'b0, 4'd0,  7'd1, 1'b0},
    {1'b0, 1'b0, 4'd0,  7'd1, 1'b0},
    {1'b1, 1'b1, 4'd1,  7'd1, 1'b0},
    {1'b1, 1'b1, 4'd2,  7'd1, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic checkNow(string tag, bit valid, int step, int row, bit sync);
    logic [5:0] expLines, gotLines;
    expLines = valid ? benchPat[step] : 6'd0;
    gotLines = {latchStb, calStrobe, rdStrobe, clampRst, diodeRst, pwrOn};
    vectors++;
    if (gotLines !== expLines || rowSel !== 7'(row) || frameSync !== sync) begin
      misses++;
      $display("FAIL %s: lines=%b row=%0d sync=%b expected lines=%b row=%0d sync=%b",
               tag, gotLines, rowSel, frameSync, expLines, row, sync);
    end
  endtask

  task automatic runTick(string tag);
    runEn = 1'b1;
    tick();
    checkNow(tag, 1'b1, pos % STEPS, pos / STEPS, pos == 0);
    pos = (pos + 1) % FRAME;
  endtask

  task automatic stopTick(string tag);
    tick();
    checkNow(tag, 1'b0, 0, pos / STEPS, 1'b0);
  endtask

  task automatic loadPattern();
    progEn = 1'b1;
    for (int k = STEPS*6 - 1; k >= 0; k--) begin
      progBit    = benchPat[k / 6][k % 6];
      progStrobe = 1'b1;
      tick();
      progStrobe = 1'b0;
      tick();
      if (k == 48) checkNow("R7", 1'b0, 0, pos / STEPS, 1'b0);
      else tick();
    end
    progEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // Pattern A: power across the slot, read, resets, second read, latch
    for (int s = 0; s < STEPS; s++) begin
      benchPat[s] = 6'd0;
      benchPat[s][0] = (s <= 13);
      benchPat[s][3] = (s >= 1 && s <= 4);
      benchPat[s][1] = (s == 5 || s == 6);
      benchPat[s][2] = (s == 7 || s == 8);
      benchPat[s][4] = (s >= 9 && s <= 11);
      benchPat[s][5] = (s >= 12 && s <= 14);
    end

    repeat (3) tick();
    checkNow("R8", 1'b0, 0, 0, 1'b0);        // reset state
    rst = 1'b0;
    pos = 0;
    loadPattern();                           // R1 with R7 check inside

    // Table walk: R2, R3, R5, R6, R9
    for (int i = 0; i < NVEC; i++) begin
      runEn = VEC[i][13];
      tick();
      checkNow(VEC[i][13] ? "R2" : "R6", VEC[i][12], int'(VEC[i][11:8]),
               int'(VEC[i][7:1]), VEC[i][0]);
    end

    // Reset mid-run keeps the pattern (R8), restart at step 0 row 0 (R9)
    rst = 1'b1;
    runEn = 1'b1;
    tick();
    checkNow("R8", 1'b0, 0, 0, 1'b0);
    rst = 1'b0;
    pos = 0;
    runTick("R9");

    // Full frame, every cycle (R3), then wrap and sync (R4, R5)
    for (int i = 1; i < FRAME; i++) runTick("R3");
    runTick("R4");
    for (int i = 1; i < FRAME - 1; i++) runTick("R5");

    // Hold exactly on the frame boundary (R6), then resume (R4, R5)
    runEn = 1'b0;
    for (int i = 0; i < 3; i++) stopTick("R6");
    runTick("R4");
    runTick("R5");

    // Programming mode blocks playback even with runEn high (R7)
    progEn = 1'b1;
    runEn  = 1'b1;
    stopTick("R7");
    stopTick("R7");
    progEn = 1'b0;
    runTick("R7");

    // Bit order of the serial load (R1)
    rst = 1'b1;
    runEn = 1'b0;
    tick();
    rst = 1'b0;
    pos = 0;
    for (int s = 0; s < STEPS; s++) benchPat[s] = 6'd0;
    benchPat[15] = 6'b100000;
    benchPat[0]  = 6'b000001;
    benchPat[3]  = 6'b010100;
    benchPat[8]  = 6'b001010;
    loadPattern();
    for (int i = 0; i < STEPS; i++) runTick("R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule